// File: doc/BRIEF.md
# MSDU buffer-chain descriptor tracker

The tracker takes receive buffer descriptors, one per accepted handshake, and groups consecutive buffers that belong to one MSDU into a single result. Each descriptor is four 32-bit words: a 40-bit buffer address with a return-manager code and a software cookie, a word of MSDU information flags, and a reserved word. A buffer whose continuation bit is set is followed by more buffers of the same MSDU. The chain closes at the first buffer with continuation clear.

Fields become valid at different points of a chain. The length and the chain head (address, return manager, cookie) come from the first buffer. Routing, drop and address-search flags come from the final buffer. The block emits one result per MSDU, one cycle after the closing descriptor is accepted. The result is either a forward to a three-bit destination ring or a drop. It also carries the buffer count, the MPDU boundary marks and error flags. Destination codes 0 to 6 select a ring directly. Codes 7 to 31 pass through a 25-entry table that is written through a simple write port.

Malformed input does not stall the stream. A descriptor with the last-MSDU flag and the continuation flag both set is flagged on the chain's result. A nonzero reserved field closes the chain at once as a drop, and so does a chain that reaches MAX_BUFS buffers with continuation still set. Both of these set a sticky error bit, and the next descriptor starts a new chain.

Top module: `msdu_chain_tracker`

## Requirements
- R1: An accepted descriptor with continuation (word 2 bit 0 = first-MSDU, bit 1 = last-MSDU, bit 2 = continuation) clear, in a clean state, produces exactly one result with res_valid_o high for one cycle, in the cycle after acceptance, with res_nbufs_o = 1.
- R2: Descriptors with continuation set join the open chain. The result appears only after the buffer with continuation clear, and res_nbufs_o equals the number of buffers in the chain.
- R3: res_len_o is word 2 bits 16:3 of the first buffer of the chain. The same field in later buffers has no effect.
- R4: These result flags are taken from the final buffer only: first, last, drop (bit 22), destination (bits 21:17), SA-valid (bit 23), SA-timeout (bit 24), DA-valid (bit 25), DA-multicast (bit 26) and DA-timeout (bit 27).
- R5: res_only_o is high exactly when both the first and the last flag of the final buffer are set.
- R6: When the final buffer's drop flag is set, res_drop_o = 1 and res_ring_o = 0.
- R7: Destination codes 0 to 6 give res_ring_o equal to the code. A code c from 7 to 31 gives the table entry at index c-7. Table entries reset to 0. A write (remap_we_i, remap_idx_i, remap_data_i) in the same cycle as a lookup of that entry leaves the lookup on the old value, and later lookups see the new value.
- R8: res_da_mcbc_o is high only when both the DA-multicast flag and the DA-valid flag of the final buffer are set.
- R9: A buffer with last-MSDU and continuation both set does not end the chain. It sets res_proto_err_o on that chain's result. A following clean chain reports res_proto_err_o = 0.
- R10: A nonzero word 2 bits 31:28 or a nonzero word 3 closes the chain at that descriptor. The result then has res_fmt_err_o = 1, res_drop_o = 1, ring 0 and all first, last, only, SA and DA flags at 0, and err_sticky_o becomes 1 and stays 1.
- R11: When the MAX_BUFS-th buffer of a chain still has continuation set, the chain closes as in R10 with res_nbufs_o = MAX_BUFS. The next descriptor starts a new chain. A chain of exactly MAX_BUFS buffers whose last buffer has continuation clear closes normally.
- R12: The head fields come from the first buffer of the chain: res_head_addr_o = {word 1 bits 7:0, word 0}, res_head_rbm_o = word 1 bits 10:8 and res_head_cookie_o = word 1 bits 31:11.
- R13: After reset, res_valid_o = 0, err_sticky_o = 0 and desc_ready_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| desc_valid_i | input | 1 | Descriptor valid |
| desc_ready_o | output | 1 | Descriptor ready (always accepting) |
| desc_w0_i | input | 32 | Descriptor word 0: address low bits |
| desc_w1_i | input | 32 | Descriptor word 1: address high bits, return manager, cookie |
| desc_w2_i | input | 32 | Descriptor word 2: MSDU flags, length, destination |
| desc_w3_i | input | 32 | Descriptor word 3: reserved |
| remap_we_i | input | 1 | Remap table write enable |
| remap_idx_i | input | 5 | Remap table index (code minus 7) |
| remap_data_i | input | 3 | Remap table entry value |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_drop_o | output | 1 | MSDU dropped |
| res_ring_o | output | 3 | Destination ring, 0 on drop |
| res_len_o | output | 14 | MSDU length from the first buffer |
| res_nbufs_o | output | 4 | Buffers in the chain |
| res_first_o | output | 1 | First MSDU in MPDU |
| res_last_o | output | 1 | Last MSDU in MPDU |
| res_only_o | output | 1 | Only MSDU in MPDU |
| res_sa_valid_o | output | 1 | Source search hit |
| res_sa_timeout_o | output | 1 | Source search timed out |
| res_da_valid_o | output | 1 | Destination search hit |
| res_da_mcbc_o | output | 1 | Destination group address, qualified |
| res_da_timeout_o | output | 1 | Destination search timed out |
| res_proto_err_o | output | 1 | Last-with-continuation seen in chain |
| res_fmt_err_o | output | 1 | Chain closed by reserved or length error |
| res_head_addr_o | output | 40 | First buffer address |
| res_head_rbm_o | output | 3 | First buffer return-manager code |
| res_head_cookie_o | output | 21 | First buffer cookie |
| err_sticky_o | output | 1 | Sticky format error |

## Verification
Table maintenance and routing can happen in the same cycle. The bench drives a remap write in the cycle that accepts a closing descriptor whose code uses that same table entry. It expects the old entry in that result and the new entry in the next one. Error closing and chain counting can also coincide. The bench sends a MAX_BUFS-th buffer that still has continuation set, and separately a reserved-field error inside an open chain. After each, it checks that the error result carries the right count and that the very next descriptor is counted as a fresh chain.

// File: rtl/msdu_trk_pkg.sv
package msdu_trk_pkg;
  localparam int unsigned ADDR_W   = 40;
  localparam int unsigned RBM_W    = 3;
  localparam int unsigned COOKIE_W = 21;
  localparam int unsigned LEN_W    = 14;
  localparam int unsigned DEST_W   = 5;
  localparam int unsigned RING_W   = 3;
  localparam int unsigned N_DIRECT = 7;
  localparam int unsigned N_REMAP  = (2 ** DEST_W) - N_DIRECT;
  localparam int unsigned IDX_W    = $clog2(N_REMAP);

  typedef struct packed {
    logic              first;
    logic              last;
    logic              cont;
    logic [LEN_W-1:0]  len;
    logic [DEST_W-1:0] dest;
    logic              drop;
    logic              sa_valid;
    logic              sa_to;
    logic              da_valid;
    logic              da_mcbc;
    logic              da_to;
    logic              rsvd_bad;
  } info_t;

  typedef struct packed {
    logic [ADDR_W-1:0]   addr;
    logic [RBM_W-1:0]    rbm;
    logic [COOKIE_W-1:0] cookie;
  } head_t;

  typedef struct packed {
    logic              drop;
    logic [RING_W-1:0] ring;
    logic [LEN_W-1:0]  len;
    logic              first;
    logic              last;
    logic              only;
    logic              sa_valid;
    logic              sa_to;
    logic              da_valid;
    logic              da_mcbc;
    logic              da_to;
    logic              proto_err;
    logic              fmt_err;
    head_t             head;
  } res_t;
endpackage

// File: rtl/msdu_desc_dec.sv
module msdu_desc_dec
  import msdu_trk_pkg::*;
(
  input  logic [31:0] w0_i,
  input  logic [31:0] w1_i,
  input  logic [31:0] w2_i,
  input  logic [31:0] w3_i,
  output info_t       info_o,
  output head_t       head_o
);
  always_comb begin
    info_o.first    = w2_i[0];
    info_o.last     = w2_i[1];
    info_o.cont     = w2_i[2];
    info_o.len      = w2_i[16:3];
    info_o.dest     = w2_i[21:17];
    info_o.drop     = w2_i[22];
    info_o.sa_valid = w2_i[23];
    info_o.sa_to    = w2_i[24];
    info_o.da_valid = w2_i[25];
    info_o.da_mcbc  = w2_i[26];
    info_o.da_to    = w2_i[27];
    info_o.rsvd_bad = (|w2_i[31:28]) | (|w3_i);
    head_o.addr     = {w1_i[7:0], w0_i};
    head_o.rbm      = w1_i[10:8];
    head_o.cookie   = w1_i[31:11];
  end
endmodule

// File: rtl/msdu_dest_remap.sv
module msdu_dest_remap
  import msdu_trk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [RING_W-1:0] data_i,
  input  logic [DEST_W-1:0] code_i,
  output logic [RING_W-1:0] ring_o
);
  logic [RING_W-1:0] tbl_q [N_REMAP];
  logic [DEST_W-1:0] off;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < N_REMAP; e++) tbl_q[e] <= '0;
    end else if (we_i) begin
      for (int e = 0; e < N_REMAP; e++)
        if (idx_i == IDX_W'(e)) tbl_q[e] <= data_i;
    end
  end

  // lookup reads the registered table: a same-cycle write is seen next cycle
  always_comb begin
    off = code_i - DEST_W'(N_DIRECT);
    if (code_i < DEST_W'(N_DIRECT)) ring_o = code_i[RING_W-1:0];
    else                            ring_o = tbl_q[off];
  end
endmodule

// File: rtl/msdu_chain_ctl.sv
module msdu_chain_ctl
  import msdu_trk_pkg::*;
#(
  parameter int unsigned MAX_BUFS = 8,
  parameter int unsigned CNT_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  info_t             info_i,
  input  head_t             head_i,
  input  logic [RING_W-1:0] ring_i,
  output logic              res_valid_o,
  output res_t              res_o,
  output logic [CNT_W-1:0]  res_nbufs_o,
  output logic              err_sticky_o
);
  logic             in_chain_q, pe_q, sticky_q, valid_q;
  logic [CNT_W-1:0] cnt_q, nbufs_q, n_bufs;
  logic [LEN_W-1:0] len_q, cur_len;
  head_t            head_q, cur_head;
  res_t             res_q, res_d;
  logic             first_buf, cur_pe, fmt_bad, close, keep;

  always_comb begin
    first_buf = !in_chain_q;
    n_bufs    = (first_buf ? '0 : cnt_q) + CNT_W'(1);
    cur_len   = first_buf ? info_i.len : len_q;
    cur_head  = first_buf ? head_i : head_q;
    cur_pe    = (!first_buf & pe_q) | (info_i.last & info_i.cont);
    fmt_bad   = info_i.rsvd_bad | (info_i.cont & (n_bufs == CNT_W'(MAX_BUFS)));
    close     = fmt_bad | !info_i.cont;
    keep      = !fmt_bad;

    res_d.drop      = fmt_bad | info_i.drop;
    res_d.ring      = res_d.drop ? '0 : ring_i;
    res_d.len       = cur_len;
    res_d.first     = keep & info_i.first;
    res_d.last      = keep & info_i.last;
    res_d.only      = keep & info_i.first & info_i.last;
    res_d.sa_valid  = keep & info_i.sa_valid;
    res_d.sa_to     = keep & info_i.sa_to;
    res_d.da_valid  = keep & info_i.da_valid;
    res_d.da_mcbc   = keep & info_i.da_valid & info_i.da_mcbc;
    res_d.da_to     = keep & info_i.da_to;
    res_d.proto_err = cur_pe;
    res_d.fmt_err   = fmt_bad;
    res_d.head      = cur_head;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_chain_q <= 1'b0;
      pe_q       <= 1'b0;
      sticky_q   <= 1'b0;
      valid_q    <= 1'b0;
      cnt_q      <= '0;
      nbufs_q    <= '0;
      len_q      <= '0;
      head_q     <= '0;
      res_q      <= '0;
    end else begin
      valid_q <= acc_i & close;
      if (acc_i) begin
        if (close) begin
          in_chain_q <= 1'b0;
          res_q      <= res_d;
          nbufs_q    <= n_bufs;
        end else begin
          in_chain_q <= 1'b1;
          cnt_q      <= n_bufs;
          len_q      <= cur_len;
          head_q     <= cur_head;
          pe_q       <= cur_pe;
        end
        if (fmt_bad) sticky_q <= 1'b1;
      end
    end
  end

  assign res_valid_o  = valid_q;
  assign res_o        = res_q;
  assign res_nbufs_o  = nbufs_q;
  assign err_sticky_o = sticky_q;
endmodule

// File: rtl/msdu_chain_tracker.sv
module msdu_chain_tracker
  import msdu_trk_pkg::*;
#(
  parameter  int unsigned MAX_BUFS = 8,
  localparam int unsigned CNT_W    = $clog2(MAX_BUFS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                desc_valid_i,
  output logic                desc_ready_o,
  input  logic [31:0]         desc_w0_i,
  input  logic [31:0]         desc_w1_i,
  input  logic [31:0]         desc_w2_i,
  input  logic [31:0]         desc_w3_i,
  input  logic                remap_we_i,
  input  logic [IDX_W-1:0]    remap_idx_i,
  input  logic [RING_W-1:0]   remap_data_i,
  output logic                res_valid_o,
  output logic                res_drop_o,
  output logic [RING_W-1:0]   res_ring_o,
  output logic [LEN_W-1:0]    res_len_o,
  output logic [CNT_W-1:0]    res_nbufs_o,
  output logic                res_first_o,
  output logic                res_last_o,
  output logic                res_only_o,
  output logic                res_sa_valid_o,
  output logic                res_sa_timeout_o,
  output logic                res_da_valid_o,
  output logic                res_da_mcbc_o,
  output logic                res_da_timeout_o,
  output logic                res_proto_err_o,
  output logic                res_fmt_err_o,
  output logic [ADDR_W-1:0]   res_head_addr_o,
  output logic [RBM_W-1:0]    res_head_rbm_o,
  output logic [COOKIE_W-1:0] res_head_cookie_o,
  output logic                err_sticky_o
);
  info_t             info;
  head_t             head;
  res_t              res;
  logic [RING_W-1:0] ring;
  logic              acc;

  assign desc_ready_o = 1'b1;
  assign acc          = desc_valid_i & desc_ready_o;

  msdu_desc_dec u_dec (
    .w0_i   (desc_w0_i),
    .w1_i   (desc_w1_i),
    .w2_i   (desc_w2_i),
    .w3_i   (desc_w3_i),
    .info_o (info),
    .head_o (head)
  );

  msdu_dest_remap u_remap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (remap_we_i),
    .idx_i  (remap_idx_i),
    .data_i (remap_data_i),
    .code_i (info.dest),
    .ring_o (ring)
  );

  msdu_chain_ctl #(.MAX_BUFS(MAX_BUFS), .CNT_W(CNT_W)) u_chain (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .acc_i        (acc),
    .info_i       (info),
    .head_i       (head),
    .ring_i       (ring),
    .res_valid_o  (res_valid_o),
    .res_o        (res),
    .res_nbufs_o  (res_nbufs_o),
    .err_sticky_o (err_sticky_o)
  );

  assign res_drop_o        = res.drop;
  assign res_ring_o        = res.ring;
  assign res_len_o         = res.len;
  assign res_first_o       = res.first;
  assign res_last_o        = res.last;
  assign res_only_o        = res.only;
  assign res_sa_valid_o    = res.sa_valid;
  assign res_sa_timeout_o  = res.sa_to;
  assign res_da_valid_o    = res.da_valid;
  assign res_da_mcbc_o     = res.da_mcbc;
  assign res_da_timeout_o  = res.da_to;
  assign res_proto_err_o   = res.proto_err;
  assign res_fmt_err_o     = res.fmt_err;
  assign res_head_addr_o   = res.head.addr;
  assign res_head_rbm_o    = res.head.rbm;
  assign res_head_cookie_o = res.head.cookie;
endmodule

// File: rtl/msdu_chain_tracker_chk.sv
module msdu_chain_tracker_chk #(
  parameter  int unsigned MAX_BUFS = 8,
  localparam int unsigned CNT_W    = $clog2(MAX_BUFS + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             desc_valid_i,
  input logic             desc_ready_o,
  input logic [31:0]      desc_w2_i,
  input logic [31:0]      desc_w3_i,
  input logic             res_valid_o,
  input logic             res_drop_o,
  input logic [2:0]       res_ring_o,
  input logic [CNT_W-1:0] res_nbufs_o,
  input logic             res_first_o,
  input logic             res_last_o,
  input logic             res_only_o,
  input logic             res_da_valid_o,
  input logic             res_da_mcbc_o,
  input logic             res_fmt_err_o,
  input logic             err_sticky_o
);
  // R1: a clean closing descriptor yields a result next cycle
  a_r1_close_gives_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_i && desc_ready_o && !desc_w2_i[2]) |=> res_valid_o);

  // R2: results only follow an accepted descriptor
  a_r2_result_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(desc_valid_i && desc_ready_o));

  a_r2_nbufs_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (res_nbufs_o >= CNT_W'(1) && res_nbufs_o <= CNT_W'(MAX_BUFS)));

  a_r5_only_implies_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_only_o) |-> (res_first_o && res_last_o));

  a_r6_drop_no_ring: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_drop_o) |-> (res_ring_o == 3'd0));

  a_r8_mcbc_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_da_mcbc_o) |-> res_da_valid_o);

  a_r10_rsvd_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_i && desc_ready_o && ((|desc_w2_i[31:28]) || (|desc_w3_i)))
      |=> (res_valid_o && res_fmt_err_o && res_drop_o && err_sticky_o));

  a_r10_sticky_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_sticky_o |=> err_sticky_o);

  a_r11_fmt_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_fmt_err_o) |-> (res_drop_o && !res_first_o && !res_last_o));
endmodule

bind msdu_chain_tracker msdu_chain_tracker_chk #(.MAX_BUFS(MAX_BUFS)) u_chk (.*);

// File: tb/msdu_chain_tracker_tb_top.sv
`timescale 1ns/1ps
module msdu_chain_tracker_tb_top;
  localparam int unsigned MAXB = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dv = 1'b0;
  logic        drdy;
  logic [31:0] w0 = '0, w1 = '0, w2 = '0, w3 = '0;
  logic        we = 1'b0;
  logic [4:0]  widx = '0;
  logic [2:0]  wdat = '0;
  logic        rv, rdrop, rfirst, rlast, ronly, rsav, rsato, rdav, rmcbc, rdato, rpe, rfe, sticky;
  logic [2:0]  rring, rrbm;
  logic [13:0] rlen;
  logic [3:0]  rnb;
  logic [39:0] raddr;
  logic [20:0] rck;

  always #10 clk = ~clk;

  msdu_chain_tracker #(.MAX_BUFS(MAXB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .desc_valid_i(dv), .desc_ready_o(drdy),
    .desc_w0_i(w0), .desc_w1_i(w1), .desc_w2_i(w2), .desc_w3_i(w3),
    .remap_we_i(we), .remap_idx_i(widx), .remap_data_i(wdat),
    .res_valid_o(rv), .res_drop_o(rdrop), .res_ring_o(rring), .res_len_o(rlen),
    .res_nbufs_o(rnb), .res_first_o(rfirst), .res_last_o(rlast), .res_only_o(ronly),
    .res_sa_valid_o(rsav), .res_sa_timeout_o(rsato), .res_da_valid_o(rdav),
    .res_da_mcbc_o(rmcbc), .res_da_timeout_o(rdato), .res_proto_err_o(rpe),
    .res_fmt_err_o(rfe), .res_head_addr_o(raddr), .res_head_rbm_o(rrbm),
    .res_head_cookie_o(rck), .err_sticky_o(sticky)
  );

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic [95:0] exp_q [$];
  string       tag_q [$];

  // bench-side model
  bit          m_in = 1'b0, m_pe = 1'b0, m_sticky = 1'b0;
  int          m_cnt = 0;
  logic [13:0] m_len;
  logic [63:0] m_head;
  logic [2:0]  m_tbl [25];

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_w2(bit f, bit l, bit c, logic [13:0] len, logic [4:0] dst,
                                        bit drp, logic [4:0] srch);
    return {4'h0, srch, drp, dst, len, c, l, f};
  endfunction

  task automatic send_w(input logic [39:0] addr, input logic [2:0] rbm, input logic [20:0] ck,
                        input logic [31:0] d2, input logic [31:0] d3, input string tag,
                        input bit wr, input logic [4:0] idx, input logic [2:0] dat);
    bit fe, drp;
    logic [2:0] ring;
    w0 = addr[31:0]; w1 = {ck, rbm, addr[39:32]}; w2 = d2; w3 = d3; dv = 1'b1;
    we = wr; widx = idx; wdat = dat;
    if (!m_in) begin
      m_len = d2[16:3]; m_head = {addr, rbm, ck}; m_cnt = 0; m_pe = 1'b0;
    end
    m_cnt++;
    m_pe = m_pe | (d2[1] & d2[2]);
    fe = (d2[31:28] != 0) || (d3 != 0) || (d2[2] && m_cnt == MAXB);
    if (fe || !d2[2]) begin
      drp  = fe | d2[22];
      ring = drp ? 3'd0 : (d2[21:17] < 7 ? d2[19:17] : m_tbl[d2[21:17] - 5'd7]);
      if (fe) exp_q.push_back({1'b1, 3'd0, m_len, 4'(m_cnt), 8'd0, m_pe, 1'b1, m_head});
      else exp_q.push_back({drp, ring, m_len, 4'(m_cnt), d2[0], d2[1], d2[0] & d2[1],
                            d2[23], d2[24], d2[25], d2[26] & d2[25], d2[27], m_pe, 1'b0, m_head});
      tag_q.push_back(tag);
      m_in = 1'b0;
      if (fe) m_sticky = 1'b1;
    end else m_in = 1'b1;
    if (wr && idx < 25) m_tbl[idx] = dat;
    @(negedge clk);
    dv = 1'b0; we = 1'b0;
  endtask

  task automatic send(input logic [39:0] addr, input logic [31:0] d2, input logic [31:0] d3,
                      input string tag);
    send_w(addr, addr[2:0], addr[20:0] ^ 21'h15a5a, d2, d3, tag, 1'b0, 5'd0, 3'd0);
  endtask

  task automatic tbl_write(input logic [4:0] idx, input logic [2:0] dat);
    we = 1'b1; widx = idx; wdat = dat;
    if (idx < 25) m_tbl[idx] = dat;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare results in arrival order
  always @(negedge clk) begin
    if (rst_n && rv) begin
      logic [95:0] act;
      act = {rdrop, rring, rlen, rnb, rfirst, rlast, ronly, rsav, rsato, rdav, rmcbc, rdato,
             rpe, rfe, raddr, rrbm, rck};
      if (exp_q.size() == 0) chk(1'b0, "R1 unexpected result", act, '0);
      else begin
        logic [95:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(act === e, t, act, e);
      end
    end
  end

  initial begin
    for (int i = 0; i < 25; i++) m_tbl[i] = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rv == 1'b0 && sticky == 1'b0 && drdy == 1'b1, "R13 reset state",
        {93'd0, rv, sticky, drdy}, 96'd1);

    // single buffer, direct ring, only MSDU
    send(40'h12_3456_7890, mk_w2(1, 1, 0, 14'd1500, 5'd3, 0, 5'b00101), 0, "R1 R5 R7 single direct");
    send(40'h00_0000_0040, mk_w2(0, 1, 0, 14'd64, 5'd6, 0, 5'b10010), 0, "R1 R7 code 6");
    idle(2);

    // three-buffer chain, per-field timing, remap default 0
    send(40'hAB_0000_1000, mk_w2(1, 0, 1, 14'd3000, 5'd1, 1, 5'b11111), 0, "R2");
    send(40'hCD_0000_2000, mk_w2(0, 1, 1, 14'd77, 5'd2, 0, 5'b00000), 0, "R2");
    send(40'hEF_0000_3000, mk_w2(1, 0, 0, 14'd5, 5'd10, 0, 5'b01011), 0, "R2 R3 R4 R7 R9 R12 chain");
    // clean chain after a flagged one
    send(40'h01_0000_0100, mk_w2(0, 0, 1, 14'd200, 5'd0, 0, 0), 0, "R9");
    send(40'h02_0000_0200, mk_w2(0, 0, 0, 14'd9, 5'd4, 0, 0), 0, "R9 clean chain R3");

    // remap table
    tbl_write(5'd3, 3'd5);
    tbl_write(5'd24, 3'd7);
    send(40'h03_0000_0300, mk_w2(1, 1, 0, 14'd100, 5'd10, 0, 0), 0, "R7 remap code 10");
    send(40'h04_0000_0400, mk_w2(1, 1, 0, 14'd101, 5'd31, 0, 0), 0, "R7 remap code 31");
    send(40'h05_0000_0500, mk_w2(1, 1, 0, 14'd102, 5'd7, 0, 0), 0, "R7 code 7 default");
    // same-cycle write and lookup of entry 3
    send_w(40'h06_0000_0600, 3'd1, 21'h1, mk_w2(1, 1, 0, 14'd103, 5'd10, 0, 0), 0,
           "R7 write same cycle old value", 1'b1, 5'd3, 3'd2);
    send(40'h07_0000_0700, mk_w2(1, 1, 0, 14'd104, 5'd10, 0, 0), 0, "R7 new value");

    // drop
    send(40'h08_0000_0800, mk_w2(1, 0, 0, 14'd50, 5'd31, 1, 5'b00011), 0, "R6 drop");
    send(40'h09_0000_0900, mk_w2(0, 0, 1, 14'd51, 5'd2, 1, 0), 0, "R6");
    send(40'h0A_0000_0A00, mk_w2(0, 0, 0, 14'd52, 5'd2, 0, 0), 0, "R4 R6 drop only from last");

    // DA multicast qualification
    send(40'h0B_0000_0B00, mk_w2(1, 1, 0, 14'd60, 5'd1, 0, 5'b01000), 0, "R8 mcbc without valid");
    send(40'h0C_0000_0C00, mk_w2(1, 1, 0, 14'd61, 5'd1, 0, 5'b01100), 0, "R8 mcbc with valid");
    idle(2);
    chk(sticky == 1'b0, "R10 sticky clear before error", {95'd0, sticky}, 96'd0);

    // reserved field error mid chain, then resync
    send(40'h0D_0000_0D00, mk_w2(1, 0, 1, 14'd700, 5'd1, 0, 0), 0, "R10");
    send(40'h0E_0000_0E00, mk_w2(1, 1, 1, 14'd701, 5'd1, 0, 5'b11111), 32'h1, "R10 word3 nonzero");
    send(40'h0F_0000_0F00, mk_w2(1, 1, 0, 14'd702, 5'd2, 0, 0), 0, "R10 resync");
    send(40'h10_0000_1000, mk_w2(1, 1, 0, 14'd703, 5'd2, 0, 0) | 32'h4000_0000, 0, "R10 word2 reserved");
    idle(1);
    chk(sticky == 1'b1, "R10 sticky set", {95'd0, sticky}, 96'd1);

    // exactly MAX_BUFS buffers closes normally
    for (int k = 0; k < MAXB; k++)
      send(40'h20_0000_0000 + 40'(k), mk_w2(1, 1, (k != MAXB - 1), 14'(k + 10), 5'd5, 0, 0), 0,
           "R11 exact max chain");
    // overflow: MAX_BUFS-th still continues
    for (int k = 0; k < MAXB; k++)
      send(40'h30_0000_0000 + 40'(k), mk_w2(0, 0, 1, 14'(k + 20), 5'd5, 0, 0), 0,
           "R11 overflow close");
    send(40'h31_0000_0000, mk_w2(1, 1, 0, 14'd99, 5'd5, 0, 0), 0, "R11 next is new chain");
    idle(3);
    chk(sticky == 1'b1, "R10 sticky holds", {95'd0, sticky}, 96'd1);
    chk(exp_q.size() == 0, "R1 R2 all results seen", 96'(exp_q.size()), 96'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R1 watchdog act=%0d exp=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule